// File: doc/BRIEF.md
# Dual-CPU Interrupt Routing Matrix

This block steers 71 level-type peripheral interrupt sources onto the peripheral interrupt inputs of two processors. Each processor numbers its interrupt inputs 0 to 31, and 26 of those numbers are wired to peripheral lines. For every source, each processor has its own 5-bit selector that names the input the source drives on that processor. A source can therefore reach one processor, both, or neither. Every output line is the OR of all sources steered onto it. Source slots 22 and 23 carry different signals on each processor. Processor 0 sees the shared inputs in those slots. Processor 1 sees a private pair of inputs there.

A per-processor mask can hold that processor's non-maskable input (number 14) low, whatever is steered onto it. Software reads back the live level of every source, as that processor sees it, through three packed 32-bit status words. A simple single-cycle register port handles configuration and readback. Bit 7 of the address selects the processor, and bits 6:0 select a register within that processor's bank. Routed outputs and read data are both registered, one clock after the inputs they reflect.

Top module: `irq_matrix`

## Requirements
- R1: After reset, every selector reads back 6 (an unused number), both masks read 0, and both output vectors are 0, even with every source high.
- R2: A source whose selector on a processor holds a peripheral number n drives bit n of that processor's output vector one clock after the source level is sampled. A selector written at one clock edge governs the output from the next edge on.
- R3: Numbers 6, 7, 11, 15, 16 and 29 are not peripheral lines. Their output bits stay 0, and a source that selects one of them drives nothing.
- R4: An output bit is the OR of every source whose selector on that processor names it.
- R5: The two processors' selectors are independent. Writing one processor's selector never changes the other processor's routing.
- R6: In slots 22 and 23, processor 0 takes `src_i[22]` and `src_i[23]`. Processor 1 takes `cpu1_slot_i[0]` and `cpu1_slot_i[1]` in those slots instead.
- R7: While a processor's mask (offset 72, bit 0) is 1, bit 14 of its output vector stays 0. Its other lines and the other processor are unaffected.
- R8: Offsets 80, 81 and 82 return status words 0, 1 and 2. Source n appears in word n/32 at bit n mod 32. Word 2 bits 31:7 read 0, and processor 1's words show its own slot 22/23 inputs. Each word reflects the levels at the clock edge of the read.
- R9: A selector at offset n (0 to 70) stores write data bits 4:0 and reads back zero-extended. Writes to the status offsets have no effect, and offsets that map to no register read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 71 | Peripheral source levels; slots 22 and 23 are processor 0's pair |
| cpu1_slot_i | input | 2 | Processor 1's private sources for slots 22 and 23 |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Bit 7 selects the processor, bits 6:0 the offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data for the address presented at the previous edge |
| cpu0_irq_o | output | 32 | Processor 0 interrupt inputs, indexed by number |
| cpu1_irq_o | output | 32 | Processor 1 interrupt inputs, indexed by number |

## Verification
A source change made before a clock edge appears on the output vectors at that edge. A selector or mask written at one edge therefore shows on the outputs one edge later, and read data for an address appears at the same edge that registers the address. The bench changes inputs on falling edges. It waits out exactly those edges and samples on the following falling edge. It compares each full output vector with a model built from a mirror of every write. The sweep covers every source against selector values that step through all 32 numbers, on both processors.

// File: rtl/irq_matrix_pkg.sv
package irq_matrix_pkg;
  localparam int SEL_W   = 5;
  localparam int NUM_IDS = 1 << SEL_W;
  localparam int WORD_W  = 32;
  // bank offsets that sit above the selector range
  localparam int OFF_MASK = 72;
  localparam int OFF_STAT = 80;
  typedef logic [SEL_W-1:0] sel_t;
endpackage

// File: rtl/irq_matrix_fold.sv
module irq_matrix_fold
  import irq_matrix_pkg::*;
#(
  parameter int          N_SRC     = 71,
  parameter logic [31:0] LINE_MASK = 32'hDFFE_773F,
  parameter int          NMI_LINE  = 14
) (
  input  logic [N_SRC-1:0]   src,
  input  sel_t               sel [N_SRC],
  input  logic               nmi_block,
  output logic [NUM_IDS-1:0] lines
);
  logic [NUM_IDS-1:0] hit;

  always_comb begin
    hit = '0;
    for (int s = 0; s < N_SRC; s++) begin
      if (src[s]) hit[sel[s]] = 1'b1;
    end
    lines = hit & LINE_MASK;
    if (nmi_block) lines[NMI_LINE] = 1'b0;
  end
endmodule

// File: rtl/irq_matrix_bank.sv
module irq_matrix_bank
  import irq_matrix_pkg::*;
#(
  parameter int          N_SRC     = 71,
  parameter int          IDX_W     = 7,
  parameter logic [31:0] LINE_MASK = 32'hDFFE_773F,
  parameter int          NMI_LINE  = 14,
  parameter int          UNROUTED  = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_SRC-1:0]   src,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [WORD_W-1:0]  wr_data,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [WORD_W-1:0]  rd_val,
  output logic [NUM_IDS-1:0] irq_q
);
  localparam int N_WORDS = (N_SRC + WORD_W - 1) / WORD_W;

  sel_t sel_q [N_SRC];
  logic mask_q;
  logic [NUM_IDS-1:0] lines;
  logic [N_WORDS*WORD_W-1:0] src_pad;
  logic unused_bits;

  assign src_pad     = (N_WORDS*WORD_W)'(src);
  assign unused_bits = ^wr_data[WORD_W-1:SEL_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < N_SRC; s++) sel_q[s] <= sel_t'(UNROUTED);
      mask_q <= 1'b0;
    end else if (wr_en) begin
      for (int s = 0; s < N_SRC; s++) begin
        if (wr_idx == IDX_W'(s)) sel_q[s] <= wr_data[SEL_W-1:0];
      end
      if (wr_idx == IDX_W'(OFF_MASK)) mask_q <= wr_data[0];
    end
  end

  irq_matrix_fold #(
    .N_SRC(N_SRC), .LINE_MASK(LINE_MASK), .NMI_LINE(NMI_LINE)
  ) u_fold (
    .src(src), .sel(sel_q), .nmi_block(mask_q), .lines(lines)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= '0;
    else     irq_q <= lines;
  end

  always_comb begin
    rd_val = '0;
    for (int s = 0; s < N_SRC; s++) begin
      if (rd_idx == IDX_W'(s)) rd_val = WORD_W'(sel_q[s]);
    end
    if (rd_idx == IDX_W'(OFF_MASK)) rd_val = WORD_W'(mask_q);
    for (int k = 0; k < N_WORDS; k++) begin
      if (rd_idx == IDX_W'(OFF_STAT + k)) rd_val = src_pad[k*WORD_W +: WORD_W];
    end
  end

  // R1: reset clears outputs and mask
  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> (irq_q == '0 && !mask_q));
  // R2: no active source means no output at the next edge
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (src == '0) |=> (irq_q == '0));
  // R3: numbers that are not peripheral lines never assert
  a_r3_unused_low: assert property (@(posedge clk) disable iff (rst)
    ((irq_q & ~LINE_MASK) == '0));
  // R7: mask holds the non-maskable line low
  a_r7_nmi_masked: assert property (@(posedge clk) disable iff (rst)
    mask_q |=> !irq_q[NMI_LINE]);
endmodule

// File: rtl/irq_matrix.sv
module irq_matrix
  import irq_matrix_pkg::*;
#(
  parameter int          N_SRC     = 71,
  parameter int          ADDR_W    = 8,
  parameter logic [31:0] LINE_MASK = 32'hDFFE_773F,
  parameter int          NMI_LINE  = 14,
  parameter int          UNROUTED  = 6,
  parameter int          SLOT_LO   = 22
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_SRC-1:0]   src_i,
  input  logic [1:0]         cpu1_slot_i,
  input  logic               cfg_we,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [WORD_W-1:0]  cfg_wdata,
  output logic [WORD_W-1:0]  cfg_rdata,
  output logic [NUM_IDS-1:0] cpu0_irq_o,
  output logic [NUM_IDS-1:0] cpu1_irq_o
);
  localparam int N_CPU = 2;
  localparam int IDX_W = ADDR_W - 1;

  logic [N_SRC-1:0]   cpu_src [N_CPU];
  logic [WORD_W-1:0]  bank_rd [N_CPU];
  logic [NUM_IDS-1:0] bank_irq [N_CPU];

  always_comb begin
    cpu_src[0] = src_i;
    cpu_src[1] = src_i;
    cpu_src[1][SLOT_LO]   = cpu1_slot_i[0];
    cpu_src[1][SLOT_LO+1] = cpu1_slot_i[1];
  end

  for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
    irq_matrix_bank #(
      .N_SRC(N_SRC), .IDX_W(IDX_W), .LINE_MASK(LINE_MASK),
      .NMI_LINE(NMI_LINE), .UNROUTED(UNROUTED)
    ) u_bank (
      .clk(clk),
      .rst(rst),
      .src(cpu_src[c]),
      .wr_en(cfg_we && (cfg_addr[ADDR_W-1] == 1'(c))),
      .wr_idx(cfg_addr[IDX_W-1:0]),
      .wr_data(cfg_wdata),
      .rd_idx(cfg_addr[IDX_W-1:0]),
      .rd_val(bank_rd[c]),
      .irq_q(bank_irq[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= '0;
    else     cfg_rdata <= bank_rd[cfg_addr[ADDR_W-1]];
  end

  assign cpu0_irq_o = bank_irq[0];
  assign cpu1_irq_o = bank_irq[1];
endmodule

// File: tb/irq_matrix_test.sv
module irq_matrix_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [70:0] src_i = '0;
  logic [1:0]  cpu1_slot_i = '0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata, cpu0_irq_o, cpu1_irq_o;

  int total = 0;
  int bad = 0;
  bit done = 0;
  int sel_m [2][71];
  bit msk_m [2];

  always #10 clk = ~clk;

  irq_matrix uut (
    .clk(clk), .rst(rst), .src_i(src_i), .cpu1_slot_i(cpu1_slot_i),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .cpu0_irq_o(cpu0_irq_o), .cpu1_irq_o(cpu1_irq_o)
  );

  function automatic bit is_line(int n);
    return !(n == 6 || n == 7 || n == 11 || n == 15 || n == 16 || n == 29);
  endfunction

  function automatic logic [70:0] eff(int c);
    logic [70:0] v = src_i;
    if (c == 1) begin
      v[22] = cpu1_slot_i[0];
      v[23] = cpu1_slot_i[1];
    end
    return v;
  endfunction

  function automatic logic [31:0] model(int c);
    logic [31:0] r = '0;
    logic [70:0] v = eff(c);
    for (int s = 0; s < 71; s++)
      if (v[s] && is_line(sel_m[c][s])) r[sel_m[c][s]] = 1'b1;
    if (msk_m[c]) r[14] = 1'b0;
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int c, int off, logic [31:0] d);
    cfg_we = 1'b1;
    cfg_addr = 8'((c << 7) | off);
    cfg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
    if (off < 71) sel_m[c][off] = int'(d[4:0]);
    if (off == 72) msk_m[c] = d[0];
  endtask

  task automatic rd(int c, int off, output logic [31:0] v);
    cfg_addr = 8'((c << 7) | off);
    @(posedge clk);
    @(negedge clk);
    v = cfg_rdata;
  endtask

  task automatic check_irq(string req);
    @(posedge clk);
    @(negedge clk);
    check({req, " cpu0"}, cpu0_irq_o, model(0));
    check({req, " cpu1"}, cpu1_irq_o, model(1));
  endtask

  task automatic check_status(string req);
    logic [31:0] v;
    logic [95:0] pad;
    for (int c = 0; c < 2; c++) begin
      for (int k = 0; k < 3; k++) begin
        rd(c, 80 + k, v);
        pad = 96'(eff(c));
        check(req, v, pad[k*32 +: 32]);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    for (int c = 0; c < 2; c++) begin
      for (int s = 0; s < 71; s++) sel_m[c][s] = 6;
      msk_m[c] = 1'b0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check("R1 cpu0 out", cpu0_irq_o, 32'h0);
    check("R1 cpu1 out", cpu1_irq_o, 32'h0);
    for (int c = 0; c < 2; c++) begin
      for (int s = 0; s < 71; s++) begin
        rd(c, s, v);
        check("R1 selector", v, 32'd6);
      end
      rd(c, 72, v);
      check("R1 mask", v, 32'd0);
    end
    src_i = '1;
    cpu1_slot_i = 2'b11;
    check_irq("R1 all high unrouted");
    check("R1 direct cpu0", cpu0_irq_o, 32'h0);

    // R2/R3: every source against stepped selector values, both CPUs
    for (int c = 0; c < 2; c++) begin
      for (int s = 0; s < 71; s++) begin
        src_i = '0;
        cpu1_slot_i = '0;
        wr(c, s, 32'((s + 9 * c) % 32));
        src_i[s] = 1'b1;
        if (s == 22 || s == 23) cpu1_slot_i = 2'b11;
        check_irq("R2/R3 sweep");
        wr(c, s, 32'd6);
      end
    end

    // R3: every number on one source of CPU0
    src_i = '0;
    cpu1_slot_i = '0;
    src_i[5] = 1'b1;
    for (int n = 0; n < 32; n++) begin
      wr(0, 5, 32'(n));
      check_irq("R3 number sweep");
    end
    wr(0, 5, 32'd6);

    // R4: OR of several sources on one line
    wr(0, 1, 32'd3);
    wr(0, 40, 32'd3);
    wr(0, 70, 32'd3);
    src_i = '0;
    src_i[40] = 1'b1;
    check_irq("R4 single of three");
    src_i[70] = 1'b1;
    check_irq("R4 two of three");
    src_i = '0;
    check_irq("R4 none");
    check("R4 line low", cpu0_irq_o, 32'h0);

    // R5: same source, different lines per CPU, then neither
    wr(1, 40, 32'd20);
    src_i[40] = 1'b1;
    check_irq("R5 both cpus");
    check("R5 cpu1 line 20", cpu1_irq_o, 32'h0010_0000);
    wr(0, 40, 32'd6);
    check_irq("R5 cpu0 cleared only");
    wr(1, 40, 32'd6);
    wr(0, 1, 32'd6);
    wr(0, 70, 32'd6);
    src_i = '0;

    // R6: slot 22/23 split
    wr(0, 22, 32'd3);
    wr(1, 22, 32'd3);
    wr(0, 23, 32'd4);
    wr(1, 23, 32'd5);
    src_i[22] = 1'b1;
    check_irq("R6 cpu0 slot22");
    check("R6 cpu1 quiet", cpu1_irq_o, 32'h0);
    src_i = '0;
    cpu1_slot_i = 2'b01;
    check_irq("R6 cpu1 slot22");
    check("R6 cpu1 line3", cpu1_irq_o, 32'h8);
    cpu1_slot_i = 2'b10;
    src_i[23] = 1'b1;
    check_irq("R6 slot23 both");
    src_i = '0;
    cpu1_slot_i = '0;

    // R7: mask on line 14
    wr(0, 10, 32'd14);
    wr(1, 10, 32'd14);
    wr(0, 11, 32'd2);
    src_i[10] = 1'b1;
    src_i[11] = 1'b1;
    check_irq("R7 unmasked");
    wr(0, 72, 32'd1);
    check_irq("R7 cpu0 masked");
    check("R7 cpu0 keeps line 2", cpu0_irq_o, 32'h4);
    rd(0, 72, v);
    check("R7 mask readback", v, 32'd1);
    wr(0, 72, 32'd0);
    check_irq("R7 unmask");
    src_i = '0;

    // R8: status words
    src_i = {7'h55, 32'hDEAD_BEEF, 32'h1234_5678};
    cpu1_slot_i = 2'b10;
    check_status("R8 status pattern a");
    src_i = ~{7'h55, 32'hDEAD_BEEF, 32'h1234_5678};
    cpu1_slot_i = 2'b01;
    check_status("R8 status pattern b");

    // R9: status writes ignored, unmapped reads zero, selector width
    wr(0, 80, 32'h0000_FFFF);
    rd(0, 80, v);
    check("R9 status write ignored", v, 32'(eff(0)));
    rd(1, 75, v);
    check("R9 unmapped", v, 32'd0);
    wr(1, 40, 32'hFFFF_FFE9);
    rd(1, 40, v);
    check("R9 selector width", v, 32'd9);
    check_irq("R9 routing after wide write");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule